// File: doc/BRIEF.md
# Page Hamming ECC controller

This block watches the words of a flash page as they cross a data bus and builds a single-error-correcting Hamming code over the whole main area in one step. On the programming path the accumulated code can be read at any time from two 16-bit registers. Software stores those registers as four code bytes in the spare area.

On the reading path the block accumulates the same code over the incoming data. It then takes in the four stored code bytes, which must arrive directly after the data. It replaces the two code registers with the syndrome and latches a status word. The status tells apart four cases: a clean page, a single flipped data bit (whose word and bit position appear in the parity register), a single flipped bit inside the code bytes, and an uncorrectable pattern.

An erased page, with all data and code bytes 0xFF, reports the uncorrectable flag with an all-ones position. Software must treat that pattern as clean. A small register port gives access to control, mode, status and the two code registers.

Top module: `page_ecc_ctrl`

## Requirements
- R1: After reset every readable register (mode 0x04, status 0x08, parity 0x0C, inverted parity 0x10) reads zero and `page_done` is low.
- R2: Writing a value with bit 0 set to the control offset 0x00 zeroes both code registers, the status and the beat counters. The mode register keeps its value. A data strobe in the same cycle is discarded.
- R3: Mode register 0x04 bits 1:0 select the page geometry 528/1056/2112/4224 bytes (codes 0..3). The protected main area is 512, 1024, 2048 or 4096 bytes respectively. Bit 4 set selects the reading (check) path, clear selects the programming path. Data beats past the main area never enter the code.
- R4: Each data bit equal to 1 sits at the 16-bit position {word offset[11:0], bit index[3:0]}. It toggles every parity-register bit where that position has a 1 and every inverted-parity bit where it has a 0. On the programming path both registers show this running code.
- R5: On the reading path the four beats after the main area carry the stored code on `dat_word[7:0]`, in the order parity low, parity high, inverted low, inverted high. In the cycle after the clock edge that accepts the fourth beat, `page_done` is high for exactly one cycle.
- R6: At the check, the parity register becomes computed-xor-stored parity and the inverted register becomes computed-xor-stored inverted parity. Status bit 0 is set for any nonzero syndrome. Bit 1 is set when exactly one syndrome bit of the 32 is set (code-field error). Bit 2 is set when the syndrome is nonzero, is not a single bit, and its two halves are not bitwise complements. A clean page gives status 0.
- R7: For a single flipped data bit the status is 3'b001, parity bits 3:0 hold the bit index, bits 15:4 hold the word offset, and the inverted register holds the complement.
- R8: An erased page, with all data and all four code bytes 0xFF, gives status 3'b101 and 0xFFFF in both code registers.
- R9: After the check, further data strobes change neither the status nor the code registers and raise no `page_done`, until the next clear. On the programming path, beats past the main area are ignored.
- R10: The word offset counts bus words of width `DW` (8 or 16). The bit index selects a bit within one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from offset) |
| dat_vld | input | 1 | Data beat valid |
| dat_word | input | DW | Data word; code bytes use bits 7:0 |
| page_done | output | 1 | One-cycle pulse when the check completes |

## Verification
The bench sends random main-area contents on both paths and compares the code registers with a bit-position model. On the reading path it sends the same data with the correct code, with one data bit flipped near the start and near the end of a 4096-byte page, with one code bit flipped, and with two data bits flipped. These cases separate the clean, correctable, code-field and uncorrectable outcomes. An erased page confirms the all-ones report. Extra beats after a 1024-byte main area, and after a completed check, show where accumulation stops. The done pulse is compared with the model on every clock, which pins down its exact cycle.

// File: rtl/pecc_pkg.sv
package pecc_pkg;
    localparam int PAR_W      = 16;
    localparam int BITF_W     = 4;
    localparam int WORDF_W    = 12;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_PAR  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_NPAR = 5'h10;

    localparam int MODE_CHK_BIT = 4;

    // bit 0 any error, bit 1 code-field error, bit 2 uncorrectable
    typedef struct packed {
        logic multi;
        logic code;
        logic any;
    } stat_t;
endpackage

// File: rtl/pecc_word_par.sv
module pecc_word_par
    import pecc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0]      word,
    input  logic [WORDF_W-1:0] waddr,
    output logic [PAR_W-1:0]   p_part,
    output logic [PAR_W-1:0]   n_part
);
    logic wpar;
    assign wpar = ^word;

    // row terms: whole-word parity split by each word-address bit
    for (genvar k = 0; k < WORDF_W; k++) begin : g_row
        assign p_part[BITF_W+k] = wpar & waddr[k];
        assign n_part[BITF_W+k] = wpar & ~waddr[k];
    end

    // column terms: bits within the word split by each bit-index bit
    for (genvar j = 0; j < BITF_W; j++) begin : g_col
        logic [DW-1:0] hi_m;
        for (genvar i = 0; i < DW; i++) begin : g_bit
            assign hi_m[i] = ((i >> j) & 1) != 0;
        end
        assign p_part[j] = ^(word & hi_m);
        assign n_part[j] = ^(word & ~hi_m);
    end
endmodule

// File: rtl/pecc_syndrome.sv
module pecc_syndrome
    import pecc_pkg::*;
(
    input  logic [PAR_W-1:0] calc_p,
    input  logic [PAR_W-1:0] calc_n,
    input  logic [PAR_W-1:0] code_p,
    input  logic [PAR_W-1:0] code_n,
    output logic [PAR_W-1:0] syn_p,
    output logic [PAR_W-1:0] syn_n,
    output stat_t            stat
);
    logic single;
    logic compl;
    logic any;

    assign syn_p  = calc_p ^ code_p;
    assign syn_n  = calc_n ^ code_n;
    assign any    = |{syn_p, syn_n};
    assign single = $countones({syn_p, syn_n}) == 1;
    assign compl  = (syn_p == ~syn_n);

    always_comb begin
        stat.any   = any;
        stat.code  = single;
        stat.multi = any & ~single & ~compl;
    end
endmodule

// File: rtl/pecc_regrd.sv
module pecc_regrd
    import pecc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              chk_mode,
    input  stat_t             stat,
    input  logic [PAR_W-1:0]  par,
    input  logic [PAR_W-1:0]  npar,
    output logic [REG_W-1:0]  rdata
);
    always_comb begin
        unique case (addr)
            OFS_MODE: rdata = {11'b0, chk_mode, 2'b00, size};
            OFS_STAT: rdata = {13'b0, stat};
            OFS_PAR:  rdata = par;
            OFS_NPAR: rdata = npar;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/page_ecc_ctrl.sv
module page_ecc_ctrl
    import pecc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int BASE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              dat_vld,
    input  logic [DW-1:0]     dat_word,
    output logic              page_done
);
    localparam int BPW        = DW / 8;
    localparam int BASE_WORDS = BASE_BYTES / BPW;
    localparam int MAX_WORDS  = BASE_WORDS << 3;
    localparam int CNT_W      = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        logic [PAR_W-1:0] par;
        logic [PAR_W-1:0] npar;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       cidx;
        logic [23:0]      code;
        logic [1:0]       size;
        logic             chk_mode;
        logic             checked;
        stat_t            stat;
        logic             done;
    } st_t;

    st_t st_q;
    st_t st_d;

    logic [PAR_W-1:0] p_part;
    logic [PAR_W-1:0] n_part;
    logic [PAR_W-1:0] syn_p;
    logic [PAR_W-1:0] syn_n;
    stat_t            syn_stat;
    logic [CNT_W-1:0] page_words;
    logic             in_data;
    logic             clr;
    logic             mode_wr;
    logic [PAR_W-1:0] code_p;
    logic [PAR_W-1:0] code_n;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[15:5], reg_wdata[3:2]};

    assign page_words = CNT_W'(BASE_WORDS) << st_q.size;
    assign in_data    = st_q.cnt < page_words;
    assign clr        = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0];
    assign mode_wr    = reg_we && (reg_addr == OFS_MODE);
    assign code_p     = st_q.code[15:0];
    assign code_n     = {dat_word[7:0], st_q.code[23:16]};

    pecc_word_par #(.DW(DW)) u_wpar (
        .word   (dat_word),
        .waddr  (WORDF_W'(st_q.cnt)),
        .p_part (p_part),
        .n_part (n_part)
    );

    pecc_syndrome u_syn (
        .calc_p (st_q.par),
        .calc_n (st_q.npar),
        .code_p (code_p),
        .code_n (code_n),
        .syn_p  (syn_p),
        .syn_n  (syn_n),
        .stat   (syn_stat)
    );

    pecc_regrd u_rd (
        .addr     (reg_addr),
        .size     (st_q.size),
        .chk_mode (st_q.chk_mode),
        .stat     (st_q.stat),
        .par      (st_q.par),
        .npar     (st_q.npar),
        .rdata    (reg_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (mode_wr) begin
            st_d.size     = reg_wdata[1:0];
            st_d.chk_mode = reg_wdata[MODE_CHK_BIT];
        end
        if (clr) begin
            st_d.par     = '0;
            st_d.npar    = '0;
            st_d.cnt     = '0;
            st_d.cidx    = '0;
            st_d.code    = '0;
            st_d.checked = 1'b0;
            st_d.stat    = '0;
        end else if (dat_vld) begin
            if (in_data) begin
                st_d.par  = st_q.par ^ p_part;
                st_d.npar = st_q.npar ^ n_part;
                st_d.cnt  = st_q.cnt + 1'b1;
            end else if (st_q.chk_mode && !st_q.checked) begin
                if (st_q.cidx != 2'd3) begin
                    st_d.code[8*st_q.cidx +: 8] = dat_word[7:0];
                    st_d.cidx                   = st_q.cidx + 1'b1;
                end else begin
                    st_d.par     = syn_p;
                    st_d.npar    = syn_n;
                    st_d.stat    = syn_stat;
                    st_d.checked = 1'b1;
                    st_d.done    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page_done = st_q.done;

    logic [2:0]       stat_w;
    logic [PAR_W-1:0] par_w;
    logic [PAR_W-1:0] npar_w;
    logic             checked_w;
    assign stat_w    = st_q.stat;
    assign par_w     = st_q.par;
    assign npar_w    = st_q.npar;
    assign checked_w = st_q.checked;
endmodule

// File: rtl/page_ecc_chk.sv
module page_ecc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [4:0]  reg_addr,
    input logic        clr_bit,
    input logic        page_done,
    input logic [2:0]  status,
    input logic [15:0] par,
    input logic [15:0] npar,
    input logic        checked
);
    logic clr;
    assign clr = reg_we && (reg_addr == 5'h00) && clr_bit;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> !page_done); // R5
    AST_DONE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> checked); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status == 3'b000 && par == 16'h0 && npar == 16'h0 && !checked)); // R2
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (checked && !clr) |=> $stable(status)); // R9
    AST_STATUS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (|status[2:1]) |-> status[0]); // R6
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[2:1])); // R6
    AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !checked |-> (status == 3'b000)); // R6
    AST_CORR_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (page_done && status == 3'b001) |-> (par == ~npar)); // R7
endmodule

bind page_ecc_ctrl page_ecc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .clr_bit   (reg_wdata[0]),
    .page_done (page_done),
    .status    (stat_w),
    .par       (par_w),
    .npar      (npar_w),
    .checked   (checked_w)
);

// File: tb/page_ecc_ctrl_tb.sv
module page_ecc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        dat_vld;
    logic [7:0]  dat_word;
    logic        page_done;

    always #2 clk = ~clk;

    page_ecc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dat_vld(dat_vld),
        .dat_word(dat_word), .page_done(page_done)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    logic exp_done = 1'b0;
    int   m_words = 512;
    bit   m_chk = 0;
    bit   m_checked = 0;
    int   m_cnt = 0;
    int   m_cidx = 0;
    logic [7:0] pg [4096];

    task automatic chk16(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // R5: done compared with the model on every clock
    task automatic cmp_done();
        n_chk++;
        if (page_done !== exp_done) begin
            n_fail++;
            $display("FAIL R5 page_done: got %b expected %b at %0t", page_done, exp_done, $time);
        end
    endtask

    task automatic drive(input bit v, input logic [7:0] d, input bit we, input logic [4:0] a, input logic [15:0] wd);
        bit clr;
        @(negedge clk);
        cmp_done();
        dat_vld = v; dat_word = d; reg_we = we; reg_addr = a; reg_wdata = wd;
        exp_done = 1'b0;
        clr = we && a == 5'h00 && wd[0];
        if (clr) begin
            m_cnt = 0; m_cidx = 0; m_checked = 0;
        end else if (v) begin
            if (m_cnt < m_words) m_cnt++;
            else if (m_chk && !m_checked) begin
                if (m_cidx < 3) m_cidx++;
                else begin m_checked = 1; exp_done = 1'b1; end
            end
        end
        if (we && a == 5'h04) begin
            m_words = 512 << wd[1:0];
            m_chk   = wd[4];
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        drive(0, 8'h00, 0, a, 16'h0);
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] wd);
        drive(0, 8'h00, 1, a, wd);
    endtask

    task automatic send_data(input int nb);
        for (int w = 0; w < nb; w++) drive(1, pg[w], 0, 5'h0, 16'h0);
    endtask

    task automatic send_page(input int nb, input logic [15:0] p, input logic [15:0] n);
        send_data(nb);
        drive(1, p[7:0], 0, 5'h0, 16'h0);
        drive(1, p[15:8], 0, 5'h0, 16'h0);
        drive(1, n[7:0], 0, 5'h0, 16'h0);
        drive(1, n[15:8], 0, 5'h0, 16'h0);
    endtask

    // each set bit toggles parity where its position has 1, inverted where 0
    task automatic calc(input int nb, output logic [15:0] p, output logic [15:0] n);
        logic [15:0] pos;
        p = '0; n = '0;
        for (int w = 0; w < nb; w++)
            for (int i = 0; i < 8; i++)
                if (pg[w][i]) begin
                    pos = {w[11:0], 4'(i)};
                    p ^= pos;
                    n ^= ~pos;
                end
    endtask

    function automatic logic [2:0] classify(input logic [15:0] sp, input logic [15:0] sn);
        int  ones;
        bit  any;
        ones = $countones({sp, sn});
        any  = (sp != 0) || (sn != 0);
        if (!any) return 3'b000;
        if (ones == 1) return 3'b011;
        if (sp == ~sn) return 3'b001;
        return 3'b101;
    endfunction

    task automatic expect_regs(input string req, input logic [2:0] st, input logic [15:0] p, input logic [15:0] n);
        logic [15:0] v;
        rd(5'h08, v); chk16(req, "status", v, {13'b0, st});
        rd(5'h0C, v); chk16(req, "parity", v, p);
        rd(5'h10, v); chk16(req, "inverted", v, n);
    endtask

    task automatic fill_random(input int nb);
        for (int i = 0; i < nb; i++) pg[i] = 8'($urandom);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v, cp, cn, fp, fn;
        rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0; dat_vld = 0; dat_word = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h04, v); chk16("R1", "mode", v, 16'h0);
        expect_regs("R1", 3'b000, 16'h0, 16'h0);

        // R4 programming path, 512-byte area
        wr(5'h04, 16'h0000); wr(5'h00, 16'h0001);
        fill_random(512);
        send_data(512);
        calc(512, cp, cn);
        expect_regs("R4", 3'b000, cp, cn);
        // R9 extra beats on programming path ignored
        drive(1, 8'h5A, 0, 0, 0); drive(1, 8'h01, 0, 0, 0);
        expect_regs("R9", 3'b000, cp, cn);

        // R6 clean read
        wr(5'h04, 16'h0010); wr(5'h00, 16'h0001);
        rd(5'h04, v); chk16("R3", "mode readback", v, 16'h0010);
        send_page(512, cp, cn);
        expect_regs("R6", 3'b000, 16'h0, 16'h0);

        // R7 single data bit at word 300 bit 5
        wr(5'h00, 16'h0001);
        pg[300][5] = ~pg[300][5];
        send_page(512, cp, cn);
        expect_regs("R7", 3'b001, 16'h12C5, ~16'h12C5);
        pg[300][5] = ~pg[300][5];

        // R6 single code-field bit: inverted low byte bit 3
        wr(5'h00, 16'h0001);
        send_page(512, cp, cn ^ 16'h0008);
        expect_regs("R6", 3'b011, 16'h0, 16'h0008);

        // R6 two data bits
        wr(5'h00, 16'h0001);
        pg[10][1] = ~pg[10][1]; pg[77][6] = ~pg[77][6];
        calc(512, fp, fn);
        chk16("R6", "model class", {13'b0, classify(fp ^ cp, fn ^ cn)}, 16'h5);
        send_page(512, cp, cn);
        expect_regs("R6", 3'b101, fp ^ cp, fn ^ cn);

        // R8 erased page
        wr(5'h00, 16'h0001);
        for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
        send_page(512, 16'hFFFF, 16'hFFFF);
        expect_regs("R8", 3'b101, 16'hFFFF, 16'hFFFF);

        // R9 beats after the check change nothing and raise no done
        for (int i = 0; i < 6; i++) drive(1, 8'(i), 0, 0, 0);
        expect_regs("R9", 3'b101, 16'hFFFF, 16'hFFFF);

        // R2 clear keeps mode
        wr(5'h00, 16'h0001);
        expect_regs("R2", 3'b000, 16'h0, 16'h0);
        rd(5'h04, v); chk16("R2", "mode kept", v, 16'h0010);

        // R3 R10 4096-byte area, flip near the end
        wr(5'h04, 16'h0013); wr(5'h00, 16'h0001);
        fill_random(4096);
        calc(4096, cp, cn);
        pg[4000][7] = ~pg[4000][7];
        send_page(4096, cp, cn);
        expect_regs("R10", 3'b001, 16'hFA07, ~16'hFA07);

        // R3 1024-byte programming path, beat 1025 excluded
        wr(5'h04, 16'h0001); wr(5'h00, 16'h0001);
        fill_random(1025);
        send_data(1025);
        calc(1024, cp, cn);
        expect_regs("R3", 3'b000, cp, cn);

        // R3 2048-byte clean read
        wr(5'h04, 16'h0012); wr(5'h00, 16'h0001);
        fill_random(2048);
        calc(2048, cp, cn);
        send_page(2048, cp, cn);
        expect_regs("R3", 3'b000, 16'h0, 16'h0);

        drive(0, 8'h00, 0, 0, 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule